// File: doc/BRIEF.md
# Packed float precision converter

This block converts floating-point values between the IEEE 754 binary32 and binary64 formats. One request carries a 128-bit operand, a direction bit (widen or narrow), a packed/scalar bit and a 2-bit rounding-mode field. A packed request converts both lanes. A scalar request converts lane 0 only and copies every other destination bit from a second 128-bit input. Widening is always exact. Narrowing rounds in the mode the request selects and can overflow, underflow, lose precision or meet a signalling NaN. Those events are collected in four sticky flags.

Requests enter through a valid/ready handshake and results leave through one. There is one output register. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` in the next cycle. The result stays stable until a cycle in which `out_ready` is high. While the output is full and `out_ready` is low, `in_ready` is low. While `in_ready` is low the caller must hold its request unchanged. The flag clear input is a plain control pin.

Top module: `fpcvt_top`

## Requirements
- R1: Widening (`in_narrow`=0) gives the exact binary64 value of each binary32 lane. This includes zeros, infinities and binary32 subnormals, which are normalised. No flag is raised except for R5.
- R2: Narrowing (`in_narrow`=1) rounds with `in_rmode`. The encoding is 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. The inexact flag is set whenever any discarded bit is nonzero.
- R3: A narrowed magnitude that does not fit binary32 after rounding sets the overflow and inexact flags. The result is infinity under mode 00, and under a directed mode that points away from zero for that sign. Otherwise the result is the largest finite value 0x7F7FFFFF with the input's sign.
- R4: A narrowed magnitude below 2^-126 before rounding is delivered as a binary32 subnormal or zero, rounded per R2. It sets the underflow flag only when it is also inexact.
- R5: A NaN input gives a quiet NaN. The sign and the highest payload bits are kept and the top fraction bit is set. A signalling NaN (top fraction bit 0) sets the invalid flag.
- R6: Packed widening puts binary32 lane i (bits 32i+31:32i) into bits 64i+63:64i. Packed narrowing puts binary64 lane i into bits 32i+31:32i and zeroes bits 127:64.
- R7: In scalar mode (`in_scalar`=1), only lane 0 is converted. All result bits above the converted lane (127:64 when widening, 127:32 when narrowing) equal the same bits of `in_keep`.
- R8: In scalar mode, flags come from lane 0 only. A NaN or overflow in lane 1 has no effect.
- R9: The flags are sticky: once set, a flag stays set until `flag_clr`. If `flag_clr` is high in a cycle that accepts a request, the old flags are dropped and the flags of that request are kept.
- R10: The result of a request accepted at edge k is on `out_data` with `out_valid` high after edge k. It is held unchanged while `out_ready` is low. `in_ready` is low exactly while a held result waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_opnd | input | 128 | Source lanes |
| in_keep | input | 128 | Bits preserved in scalar mode |
| in_narrow | input | 1 | 1: binary64 to binary32, 0: binary32 to binary64 |
| in_scalar | input | 1 | 1: lane 0 only |
| in_rmode | input | 2 | Rounding mode for narrowing |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Converted result |
| flag_clr | input | 1 | Clear the sticky flags |
| flg_inexact | output | 1 | Sticky inexact |
| flg_overflow | output | 1 | Sticky overflow |
| flg_underflow | output | 1 | Sticky underflow |
| flg_invalid | output | 1 | Sticky invalid |

## Verification
Two things can land on the same clock edge: a flag clear, and an accepted conversion that raises new flags. The bench drives `flag_clr` together with the request strobe on about one request in eight, and also on its own. It judges the flags in the following cycle against a model in which the clear drops only the old flags. The other collision is a new request arriving while a held result is back-pressured. That case is judged by `in_ready` staying low and the held data staying unchanged until `out_ready` returns.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic nx;
    logic of;
    logic uf;
    logic nv;
  } fflags_t;
endpackage

// File: rtl/fpcvt_widen.sv
module fpcvt_widen (
  input  logic [31:0]        a,
  output logic [63:0]        y,
  output fpcvt_pkg::fflags_t fl
);
  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] fr;
  logic [4:0]  top;
  logic [22:0] fnorm;

  always_comb begin
    sgn = a[31];
    ex  = a[30:23];
    fr  = a[22:0];
    fl  = '0;
    // position of the highest set fraction bit, for subnormal inputs
    top = '0;
    for (int i = 0; i < 23; i++) if (fr[i]) top = 5'(i);
    fnorm = fr << (5'd23 - top);
    if (ex == 8'hFF) begin
      if (fr == '0) y = {sgn, 11'h7FF, 52'd0};
      else begin
        y     = {sgn, 11'h7FF, 1'b1, fr[21:0], 29'd0};
        fl.nv = ~fr[22];
      end
    end else if (ex == '0) begin
      if (fr == '0) y = {sgn, 63'd0};
      else          y = {sgn, 11'(top) + 11'd874, fnorm, 29'd0};
    end else begin
      y = {sgn, 11'(ex) + 11'd896, fr, 29'd0};
    end
  end
endmodule

// File: rtl/fpcvt_narrow.sv
module fpcvt_narrow (
  input  logic [63:0]        a,
  input  fpcvt_pkg::rmode_e  rm,
  output logic [31:0]        y,
  output fpcvt_pkg::fflags_t fl
);
  import fpcvt_pkg::*;

  logic               sgn;
  logic [10:0]        ex, ex_eff;
  logic [51:0]        fr;
  logic [52:0]        sig;
  logic signed [12:0] tex, shf_full;
  logic [4:0]         shf;
  logic [84:0]        wide;
  logic [23:0]        kept;
  logic               rbit, sbit, inc, inf_ok, ovf;
  logic [7:0]         exp8;
  logic [30:0]        mag;

  always_comb begin
    sgn    = a[63];
    ex     = a[62:52];
    fr     = a[51:0];
    ex_eff = (ex == '0) ? 11'd1 : ex;
    sig    = {ex != '0, fr};
    tex    = $signed({2'b00, ex_eff}) - 13'sd896;
    shf_full = 13'sd1 - tex;
    if (tex >= 13'sd1)        shf = '0;
    else if (shf_full > 13'sd31) shf = 5'd31;
    else                      shf = shf_full[4:0];
    wide = {sig, 32'd0} >> shf;
    kept = wide[84:61];
    rbit = wide[60];
    sbit = |wide[59:0];
    unique case (rm)
      RM_NEAR: inc = rbit & (sbit | kept[0]);
      RM_DOWN: inc = (rbit | sbit) & sgn;
      RM_UP:   inc = (rbit | sbit) & ~sgn;
      default: inc = 1'b0;
    endcase
    exp8 = (tex >= 13'sd1) ? tex[7:0] : 8'd0;
    mag  = {exp8, kept[22:0]} + 31'(inc);
    ovf  = (tex >= 13'sd255) || (mag[30:23] == 8'hFF);
    inf_ok = (rm == RM_NEAR) || (rm == RM_UP && !sgn) || (rm == RM_DOWN && sgn);
    fl = '0;
    if (ex == 11'h7FF) begin
      if (fr == '0) y = {sgn, 8'hFF, 23'd0};
      else begin
        y     = {sgn, 8'hFF, 1'b1, fr[50:29]};
        fl.nv = ~fr[51];
      end
    end else if (ovf) begin
      y     = {sgn, inf_ok ? 31'h7F80_0000 : 31'h7F7F_FFFF};
      fl.of = 1'b1;
      fl.nx = 1'b1;
    end else begin
      y     = {sgn, mag};
      fl.nx = rbit | sbit;
      fl.uf = (tex <= 13'sd0) & (rbit | sbit);
    end
  end
endmodule

// File: rtl/fpcvt_top.sv
module fpcvt_top #(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LANES*64-1:0]  in_opnd,
  input  logic [LANES*64-1:0]  in_keep,
  input  logic                 in_narrow,
  input  logic                 in_scalar,
  input  logic [1:0]           in_rmode,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LANES*64-1:0]  out_data,
  input  logic                 flag_clr,
  output logic                 flg_inexact,
  output logic                 flg_overflow,
  output logic                 flg_underflow,
  output logic                 flg_invalid
);
  import fpcvt_pkg::*;

  localparam int W = LANES * 64;

  logic [63:0] w_y [LANES];
  logic [31:0] n_y [LANES];
  fflags_t     w_fl [LANES];
  fflags_t     n_fl [LANES];
  logic [W-1:0] nxt_data;
  fflags_t      nxt_fl, sticky;
  logic         accept;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fpcvt_widen u_wid (
      .a  (in_opnd[32*g +: 32]),
      .y  (w_y[g]),
      .fl (w_fl[g])
    );
    fpcvt_narrow u_nar (
      .a  (in_opnd[64*g +: 64]),
      .rm (rmode_e'(in_rmode)),
      .y  (n_y[g]),
      .fl (n_fl[g])
    );
  end

  always_comb begin
    nxt_fl = '0;
    if (in_scalar) begin
      nxt_data = in_keep;
      if (in_narrow) begin
        nxt_data[31:0] = n_y[0];
        nxt_fl         = n_fl[0];
      end else begin
        nxt_data[63:0] = w_y[0];
        nxt_fl         = w_fl[0];
      end
    end else begin
      nxt_data = '0;
      for (int i = 0; i < LANES; i++) begin
        if (in_narrow) begin
          nxt_data[32*i +: 32] = n_y[i];
          nxt_fl               = nxt_fl | n_fl[i];
        end else begin
          nxt_data[64*i +: 64] = w_y[i];
          nxt_fl               = nxt_fl | w_fl[i];
        end
      end
    end
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      sticky    <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= nxt_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      sticky <= (flag_clr ? fflags_t'('0) : sticky) | (accept ? nxt_fl : fflags_t'('0));
    end
  end

  assign flg_inexact   = sticky.nx;
  assign flg_overflow  = sticky.of;
  assign flg_underflow = sticky.uf;
  assign flg_invalid   = sticky.nv;
endmodule

// File: rtl/fpcvt_chk.sv
module fpcvt_chk #(
  parameter int LANES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LANES*64-1:0] in_keep,
  input logic                in_narrow,
  input logic                in_scalar,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*64-1:0] out_data,
  input logic                flag_clr,
  input logic                flg_inexact,
  input logic                flg_overflow,
  input logic                flg_underflow,
  input logic                flg_invalid
);
  localparam int W    = LANES * 64;
  localparam int HALF = W / 2;

  a_r10_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r9_inexact_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flg_inexact && !flag_clr |=> flg_inexact);

  a_r9_invalid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flg_invalid && !flag_clr |=> flg_invalid);

  a_r3_overflow_with_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    flg_overflow |-> flg_inexact);

  a_r4_underflow_with_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    flg_underflow |-> flg_inexact);

  a_r6_packed_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_narrow && !in_scalar |=> out_data[W-1:HALF] == '0);

  a_r7_scalar_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_narrow && in_scalar |=> out_data[W-1:32] == $past(in_keep[W-1:32]));
endmodule

bind fpcvt_top fpcvt_chk #(.LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_keep       (in_keep),
  .in_narrow     (in_narrow),
  .in_scalar     (in_scalar),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .flag_clr      (flag_clr),
  .flg_inexact   (flg_inexact),
  .flg_overflow  (flg_overflow),
  .flg_underflow (flg_underflow),
  .flg_invalid   (flg_invalid)
);

// File: tb/fpcvt_top_tb_top.sv
module fpcvt_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_narrow = 1'b0, in_scalar = 1'b0, out_ready = 1'b1, flag_clr = 1'b0;
  logic [127:0] in_opnd = '0, in_keep = '0;
  logic [1:0]   in_rmode = '0;
  logic         in_ready, out_valid;
  logic [127:0] out_data;
  logic flg_inexact, flg_overflow, flg_underflow, flg_invalid;

  int checks = 0;
  int errors = 0;
  logic [3:0] efl = '0;
  bit done = 0;

  always #2 clk = ~clk;

  fpcvt_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opnd(in_opnd), .in_keep(in_keep), .in_narrow(in_narrow), .in_scalar(in_scalar),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .flag_clr(flag_clr), .flg_inexact(flg_inexact), .flg_overflow(flg_overflow),
    .flg_underflow(flg_underflow), .flg_invalid(flg_invalid)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_widen(input logic [31:0] a, output logic [63:0] y, output logic [3:0] fl);
    logic [23:0] mt;
    int ex;
    fl = '0;
    if (a[30:23] == 8'hFF) begin
      if (a[22:0] == '0) y = {a[31], 11'h7FF, 52'd0};
      else begin
        y = {a[31], 11'h7FF, 1'b1, a[21:0], 29'd0};
        fl[0] = ~a[22];
      end
    end else if (a[30:0] == '0) begin
      y = {a[31], 63'd0};
    end else begin
      if (a[30:23] == '0) begin
        mt = {1'b0, a[22:0]};
        ex = -126;
        while (!mt[23]) begin mt = mt << 1; ex--; end
      end else begin
        mt = {1'b1, a[22:0]};
        ex = int'(a[30:23]) - 127;
      end
      y = {a[31], 11'(ex + 1023), mt[22:0], 29'd0};
    end
  endfunction

  // fl = {inexact, overflow, underflow, invalid}
  function automatic void ref_narrow(input logic [63:0] a, input logic [1:0] rm,
                                     output logic [31:0] y, output logic [3:0] fl);
    longint unsigned mm, q, r, half, bits;
    int e, s;
    bit sg, inc, nx;
    sg = a[63];
    fl = '0;
    if (a[62:52] == 11'h7FF) begin
      if (a[51:0] == '0) y = {sg, 8'hFF, 23'd0};
      else begin
        y = {sg, 8'hFF, 1'b1, a[50:29]};
        fl[0] = ~a[51];
      end
      return;
    end
    mm = {11'd0, a[62:52] != '0, a[51:0]};
    e = ((a[62:52] == '0) ? 1 : int'(a[62:52])) - 896;
    s = (e >= 1) ? 29 : 30 - e;
    if (s > 62) s = 62;
    q = mm >> s;
    r = mm & ((64'd1 << s) - 1);
    half = 64'd1 << (s - 1);
    nx = (r != 0);
    case (rm)
      2'b00: inc = (r > half) || (r == half && q[0]);
      2'b01: inc = sg && nx;
      2'b10: inc = !sg && nx;
      default: inc = 0;
    endcase
    bits = ((e >= 1) ? (longint'(e - 1) << 23) : 64'd0) + q + 64'(inc);
    if (e >= 255 || bits >= 64'h7F80_0000) begin
      fl = 4'b1100;
      if (rm == 2'b00 || (rm == 2'b10 && !sg) || (rm == 2'b01 && sg)) y = {sg, 31'h7F80_0000};
      else y = {sg, 31'h7F7F_FFFF};
    end else begin
      y = {sg, bits[30:0]};
      fl = {nx, 1'b0, (e <= 0) && nx, 1'b0};
    end
  endfunction

  function automatic void model(input logic [127:0] op, input logic [127:0] keep, input logic nar,
                                input logic sc, input logic [1:0] rm,
                                output logic [127:0] d, output logic [3:0] fl);
    logic [63:0] r64;
    logic [31:0] r32;
    logic [3:0]  f;
    d  = sc ? keep : '0;
    fl = '0;
    for (int l = 0; l < (sc ? 1 : 2); l++) begin
      if (nar) begin
        ref_narrow(op[64*l +: 64], rm, r32, f);
        d[32*l +: 32] = r32;
      end else begin
        ref_widen(op[32*l +: 32], r64, f);
        d[64*l +: 64] = r64;
      end
      fl |= f;
    end
  endfunction

  task automatic send(input logic [127:0] op, input logic [127:0] keep, input logic nar, input logic sc,
                      input logic [1:0] rm, input logic clr, input string req);
    logic [127:0] ed;
    logic [3:0]   ef;
    model(op, keep, nar, sc, rm, ed, ef);
    efl = (clr ? 4'b0 : efl) | ef;
    @(negedge clk);
    in_opnd = op; in_keep = keep; in_narrow = nar; in_scalar = sc; in_rmode = rm;
    flag_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    chk(out_valid === 1'b1, {req, " R10 valid"}, {127'd0, out_valid}, 128'd1);
    chk(out_data === ed, {req, " data"}, out_data, ed);
    chk({flg_inexact, flg_overflow, flg_underflow, flg_invalid} === efl, {req, " R9 flags"},
        {124'd0, flg_inexact, flg_overflow, flg_underflow, flg_invalid}, {124'd0, efl});
  endtask

  function automatic logic [63:0] rnd_dbl();
    logic [10:0] e;
    logic [51:0] m;
    int b;
    b = $urandom % 8;
    m = {$urandom, $urandom};
    case (b)
      0: e = 11'h7FF;
      1: e = 11'd0;
      2: e = 11'(866 + $urandom % 32);
      3: e = 11'(1148 + $urandom % 6);
      4: e = 11'($urandom);
      default: e = 11'(897 + $urandom % 253);
    endcase
    if ($urandom % 4 == 0) m[28:0] = ($urandom % 2) ? 29'h1000_0000 : 29'd0;
    return {1'($urandom), e, m};
  endfunction

  function automatic logic [31:0] rnd_sgl();
    logic [31:0] v;
    v = $urandom;
    case ($urandom % 4)
      0: v[30:23] = 8'h00;
      1: v[30:23] = 8'hFF;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R10 reset state", {126'd0, out_valid, in_ready}, 128'd1);
    chk({flg_inexact, flg_overflow, flg_underflow, flg_invalid} === 4'b0, "R9 reset flags",
        {124'd0, flg_inexact, flg_overflow, flg_underflow, flg_invalid}, 128'd0);

    // R2 exact one and ties
    send({64'h3FF0_0000_1000_0000, 64'h3FF0_0000_0000_0000}, '0, 1, 0, 2'b00, 1, "R2 tie even");
    chk(out_data[63:0] === 64'h3F80_0000_3F80_0000, "R2 tie to even value", out_data, 128'h3F80_0000_3F80_0000);
    send({64'h3FF0_0000_3000_0000, 64'h3FF0_0000_1000_0000}, '0, 1, 0, 2'b10, 1, "R2 toward plus");
    chk(out_data[63:0] === 64'h3F80_0002_3F80_0001, "R2 round up value", out_data, 128'h3F80_0002_3F80_0001);
    // R3 overflow in each mode
    for (int m = 0; m < 4; m++)
      send({64'hFFEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF}, '0, 1, 0, 2'(m), 1, "R3 overflow");
    send({64'h0, 64'h7FEF_FFFF_FFFF_FFFF}, '0, 1, 0, 2'b11, 1, "R3 toward zero");
    chk(out_data[31:0] === 32'h7F7F_FFFF, "R3 max finite", out_data, 128'h7F7F_FFFF);
    // R4 tiny values
    send({64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001}, '0, 1, 0, 2'b10, 1, "R4 min subnormal up");
    chk(out_data[31:0] === 32'h0000_0001, "R4 min subnormal", out_data, 128'h1);
    send({64'h3800_0000_0000_0000, 64'h3810_0000_0000_0000}, '0, 1, 0, 2'b00, 1, "R4 exact subnormal");
    // R5 NaNs
    send({64'h7FF8_0000_0000_0001, 64'h7FF0_0000_0000_0001}, '0, 1, 0, 2'b00, 1, "R5 narrow NaN");
    chk(out_data[31:0] === 32'h7FC0_0000, "R5 quieted", out_data, 128'h7FC0_0000);
    send({64'h0, 32'h7FC0_1234, 32'h7F80_0001}, '0, 0, 0, 2'b00, 1, "R5 widen NaN");
    chk(out_data[63:0] === 64'h7FF8_0000_2000_0000, "R5 widen quieted", out_data, 128'h7FF8_0000_2000_0000);
    // R1 subnormal widen, R6 lanes
    send({64'h0, 32'hC000_0000, 32'h0000_0001}, '0, 0, 0, 2'b00, 1, "R1 subnormal widen");
    chk(out_data === {64'hC000_0000_0000_0000, 64'h36A0_0000_0000_0000}, "R6 widen lanes", out_data,
        {64'hC000_0000_0000_0000, 64'h36A0_0000_0000_0000});
    // R7 R8 scalar keeps upper and ignores lane 1
    send({64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000}, {4{32'hA5A5_5A5A}}, 1, 1, 2'b00, 1, "R8 lane1 ignored");
    chk({flg_invalid, flg_inexact} === 2'b00, "R8 no flag from lane 1", {126'd0, flg_invalid, flg_inexact}, 128'd0);
    send({64'h1234_5678_7F80_0001, 64'h0}, {4{32'hDEAD_BEEF}}, 0, 1, 2'b00, 1, "R7 scalar widen");

    // R9 clear alone
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; efl = '0;
    chk({flg_inexact, flg_overflow, flg_underflow, flg_invalid} === 4'b0, "R9 clear alone",
        {124'd0, flg_inexact, flg_overflow, flg_underflow, flg_invalid}, 128'd0);

    // R10 back-pressure
    begin
      logic [127:0] ea, eb;
      logic [3:0] fa, fb;
      model({64'h0, 64'h3FF8_0000_0000_0000}, '0, 1, 0, 2'b00, ea, fa);
      model({64'h0, 64'h4000_0000_0000_0000}, '0, 1, 0, 2'b00, eb, fb);
      @(negedge clk);
      out_ready = 1'b0;
      in_opnd = {64'h0, 64'h3FF8_0000_0000_0000}; in_narrow = 1; in_scalar = 0; in_rmode = 0; in_valid = 1;
      @(negedge clk);
      in_opnd = {64'h0, 64'h4000_0000_0000_0000};
      chk(in_ready === 1'b0, "R10 stalled not ready", {127'd0, in_ready}, 128'd0);
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === ea, "R10 held data", out_data, ea);
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_data === eb, "R10 next after release", out_data, eb);
      efl |= fa | fb;
    end

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [127:0] op, kp;
      logic nar, sc, clr;
      nar = 1'($urandom);
      sc  = ($urandom % 4 == 0);
      clr = ($urandom % 8 == 0);
      kp  = {$urandom, $urandom, $urandom, $urandom};
      if (nar) op = {rnd_dbl(), rnd_dbl()};
      else     op = {$urandom, $urandom, rnd_sgl(), rnd_sgl()};
      send(op, kp, nar, sc, 2'($urandom), clr, nar ? "R2 R3 R4 random narrow" : "R1 R6 random widen");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule